// File: doc/BRIEF.md
# Command Ring Fetch Engine

This block drains a circular ring of 32-bit command words held in system memory and hands each one to an attached codec slot. Software places a 128-byte aligned ring base and a write index in the register interface, then sets a run bit. The engine keeps its own 8-bit read index. It moves that index forward one entry at a time, fetching each entry over a single-word memory read port. It then decodes the word into a codec address, a node id and a payload, and presents it on a command output. Words that ask for indirect node addressing, or that name a codec slot marked absent, are refused on a separate reject strobe.

Two things can hold the ring back. One is a response-count threshold: each completed codec response raises a counter, and once the counter equals the programmed threshold, fetching waits until software writes the acknowledge select. The other is an immediate-command path. A word loaded into the immediate register is sent ahead of any ring entry once its busy flag is raised. This works even while the ring is stopped.

Top module: `cmd_ring_fetch`

## Requirements
- R1: Before each fetch the read index is advanced as (index+1) mod 256, and the memory request address is base + 4*(new index). The base keeps only bits above bit 6 of the written value, so bits 6:0 of the base read as zero.
- R2: A fetch starts only while the run bit (bit 0 of the control select, code 2) is set and the read index differs from the write index (select code 1). When they are equal, the ring counts as empty and nothing is requested.
- R3: Each pulse on `rsp_done` raises a response counter, which saturates at its maximum value. Fetching holds while the counter equals the threshold (select code 3). A write to the acknowledge select (code 5) clears the counter, and that clear wins over a `rsp_done` pulse in the same cycle.
- R4: Writing 1 to bit 1 of the control select raises `imm_busy`. While it is raised, the word in the immediate register (select code 4) is dispatched before any new ring fetch starts, regardless of the run bit. `imm_busy` clears when that word is dispatched.
- R5: A dispatched word is split into codec address = bits 31:28, node id = bits 26:20 and payload = bits 19:0.
- R6: A word with bit 27 set is not sent. It raises `cmd_reject` instead of `cmd_valid`, and the two strobes are never high together.
- R7: A word whose codec address is 15, or whose slot bit in `codec_present` is 0, is not sent and raises `cmd_reject`.
- R8: Only one memory read is outstanding at a time. The read index advances, and the command strobe rises, one cycle after the returned data is taken.
- R9: After reset the read index is 0, `imm_busy` is 0 and no request or command strobe is raised. The base select is code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | 32 | Register write data |
| rsp_done | input | 1 | One pulse per codec response written |
| codec_present | input | NUM_SLOTS | Per-slot presence mask |
| rd_ptr | output | PTR_W | Hardware read index |
| imm_busy | output | 1 | Immediate command pending |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | ADDR_W | Memory read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| cmd_valid | output | 1 | Command sent to a slot |
| cmd_reject | output | 1 | Command refused |
| cmd_codec | output | 4 | Codec address field |
| cmd_node | output | 7 | Node id field |
| cmd_payload | output | 20 | Payload field |

## Verification
The immediate path and the ring fetch can both become eligible in the same cycle. The bench provokes this with a single control write that raises the run bit and the immediate flag together while unread ring entries are waiting. It judges the outcome by the order of dispatched commands: the immediate word must come out first, followed by the ring entries in index order. A second collision sets a response pulse and the acknowledge write in the same cycle with a threshold of one. The ring may then be fetched only if the clear won.

// File: rtl/cmdf_pkg.sv
package cmdf_pkg;

   localparam int unsigned BASE_ALIGN = 7;
   localparam int unsigned CODEC_W    = 4;
   localparam int unsigned NODE_W     = 7;
   localparam int unsigned PAYLOAD_W  = 20;

   typedef enum logic [2:0] {
      SEL_BASE   = 3'd0,
      SEL_WPTR   = 3'd1,
      SEL_CTRL   = 3'd2,
      SEL_THRESH = 3'd3,
      SEL_IMMW   = 3'd4,
      SEL_ACK    = 3'd5
   } reg_sel_e;

   typedef enum logic {
      FS_IDLE = 1'b0,
      FS_WAIT = 1'b1
   } fetch_st_e;

   typedef struct packed {
      logic [CODEC_W-1:0]   codec;
      logic                 indirect;
      logic [NODE_W-1:0]    node;
      logic [PAYLOAD_W-1:0] payload;
   } verb_t;

endpackage

// File: rtl/cmdf_regs.sv
module cmdf_regs
   import cmdf_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned PTR_W  = 8,
   parameter int unsigned CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [31:0]       wr_data,
   input  logic              rsp_pulse,
   input  logic              imm_taken,
   output logic [ADDR_W-1:0] base_q,
   output logic [PTR_W-1:0]  wptr_q,
   output logic              run_q,
   output logic [CNT_W-1:0]  thresh_q,
   output logic [CNT_W-1:0]  cnt_q,
   output logic [31:0]       imm_word_q,
   output logic              imm_busy_q
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   reg_sel_e sel;
   logic     unused_wdata;

   assign sel          = reg_sel_e'(wr_sel);
   assign unused_wdata = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q     <= '0;
         wptr_q     <= '0;
         run_q      <= 1'b0;
         thresh_q   <= '0;
         imm_word_q <= '0;
      end else if (wr_en) begin
         case (sel)
            SEL_BASE:   base_q     <= {wr_data[ADDR_W-1:BASE_ALIGN], {BASE_ALIGN{1'b0}}};
            SEL_WPTR:   wptr_q     <= wr_data[PTR_W-1:0];
            SEL_CTRL:   run_q      <= wr_data[0];
            SEL_THRESH: thresh_q   <= wr_data[CNT_W-1:0];
            SEL_IMMW:   imm_word_q <= wr_data;
            default:    ;
         endcase
      end
   end

   // busy: a new request in the same cycle as a dispatch wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         imm_busy_q <= 1'b0;
      else if (wr_en && sel == SEL_CTRL && wr_data[1])
         imm_busy_q <= 1'b1;
      else if (imm_taken)
         imm_busy_q <= 1'b0;
   end

   // response counter: acknowledge beats an arriving response
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (wr_en && sel == SEL_ACK)
         cnt_q <= '0;
      else if (rsp_pulse && cnt_q != CNT_MAX)
         cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/cmdf_fetch.sv
module cmdf_fetch
   import cmdf_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned PTR_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] base,
   input  logic [PTR_W-1:0]  wptr,
   input  logic              run,
   input  logic              stall_cnt,
   input  logic              imm_busy,
   input  logic [31:0]       imm_word,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_rdata,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [PTR_W-1:0]  rptr,
   output logic              take,
   output logic [31:0]       take_word,
   output logic              imm_taken
);

   localparam int unsigned OFS_W = PTR_W + 2;

   fetch_st_e        st_q;
   logic [PTR_W-1:0] nxt;
   logic             can_fetch;
   logic             ring_take;

   assign nxt       = rptr + 1'b1;
   assign can_fetch = run && (rptr != wptr) && !stall_cnt;
   assign imm_taken = (st_q == FS_IDLE) && imm_busy;
   assign ring_take = (st_q == FS_WAIT) && mem_rvalid;
   assign take      = imm_taken || ring_take;
   assign take_word = imm_taken ? imm_word : mem_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= FS_IDLE;
         mem_req  <= 1'b0;
         mem_addr <= '0;
         rptr     <= '0;
      end else begin
         mem_req <= 1'b0;
         case (st_q)
            FS_IDLE: begin
               if (!imm_busy && can_fetch) begin
                  mem_req  <= 1'b1;
                  mem_addr <= base + ADDR_W'({nxt, 2'b00});
                  st_q     <= FS_WAIT;
               end
            end
            FS_WAIT: begin
               if (mem_rvalid) begin
                  rptr <= nxt;
                  st_q <= FS_IDLE;
               end
            end
            default: st_q <= FS_IDLE;
         endcase
      end
   end

   logic [OFS_W-1:0] unused_ofs;
   assign unused_ofs = '0;

endmodule

// File: rtl/cmdf_dispatch.sv
module cmdf_dispatch
   import cmdf_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 15,
   parameter bit          OUT_REG   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 take,
   input  logic [31:0]          word,
   input  logic [NUM_SLOTS-1:0] present,
   output logic                 cmd_valid,
   output logic                 cmd_reject,
   output logic [CODEC_W-1:0]   cmd_codec,
   output logic [NODE_W-1:0]    cmd_node,
   output logic [PAYLOAD_W-1:0] cmd_payload
);

   localparam int unsigned ADDR_SPAN = 1 << CODEC_W;

   verb_t                v;
   logic [ADDR_SPAN-1:0] slot_ok;
   logic                 accept;

   assign v = verb_t'(word);

   // the top code is reserved, codes past NUM_SLOTS have no slot
   for (genvar k = 0; k < ADDR_SPAN; k++) begin : g_slot
      if (k < NUM_SLOTS && k != ADDR_SPAN - 1) begin : g_real
         assign slot_ok[k] = present[k];
      end else begin : g_none
         assign slot_ok[k] = 1'b0;
      end
   end

   assign accept = !v.indirect && slot_ok[v.codec];

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cmd_valid   <= 1'b0;
            cmd_reject  <= 1'b0;
            cmd_codec   <= '0;
            cmd_node    <= '0;
            cmd_payload <= '0;
         end else begin
            cmd_valid  <= take && accept;
            cmd_reject <= take && !accept;
            if (take) begin
               cmd_codec   <= v.codec;
               cmd_node    <= v.node;
               cmd_payload <= v.payload;
            end
         end
      end
   end else begin : g_comb
      assign cmd_valid   = take && accept;
      assign cmd_reject  = take && !accept;
      assign cmd_codec   = v.codec;
      assign cmd_node    = v.node;
      assign cmd_payload = v.payload;
   end

endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch
   import cmdf_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned PTR_W     = 8,
   parameter int unsigned CNT_W     = 8,
   parameter int unsigned NUM_SLOTS = 15,
   parameter bit          OUT_REG   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr_en,
   input  logic [2:0]           reg_sel,
   input  logic [31:0]          reg_wdata,
   input  logic                 rsp_done,
   input  logic [NUM_SLOTS-1:0] codec_present,
   output logic [PTR_W-1:0]     rd_ptr,
   output logic                 imm_busy,
   output logic                 mem_req,
   output logic [ADDR_W-1:0]    mem_addr,
   input  logic                 mem_rvalid,
   input  logic [31:0]          mem_rdata,
   output logic                 cmd_valid,
   output logic                 cmd_reject,
   output logic [3:0]           cmd_codec,
   output logic [6:0]           cmd_node,
   output logic [19:0]          cmd_payload
);

   if (ADDR_W > 32 || ADDR_W < PTR_W + 2 || ADDR_W <= BASE_ALIGN) begin : g_bad_addr
      $error("cmd_ring_fetch: ADDR_W out of range");
   end
   if (NUM_SLOTS < 1 || NUM_SLOTS > 15) begin : g_bad_slots
      $error("cmd_ring_fetch: NUM_SLOTS must be 1..15");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("cmd_ring_fetch: CNT_W must be 1..32");
   end

   logic [ADDR_W-1:0] base_q;
   logic [PTR_W-1:0]  wptr_q;
   logic              run_q;
   logic [CNT_W-1:0]  thresh_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [31:0]       imm_word_q;
   logic              imm_taken;
   logic              take;
   logic [31:0]       take_word;
   logic              stall_cnt;

   assign stall_cnt = (cnt_q == thresh_q);

   cmdf_regs #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_wr_en),
      .wr_sel     (reg_sel),
      .wr_data    (reg_wdata),
      .rsp_pulse  (rsp_done),
      .imm_taken  (imm_taken),
      .base_q     (base_q),
      .wptr_q     (wptr_q),
      .run_q      (run_q),
      .thresh_q   (thresh_q),
      .cnt_q      (cnt_q),
      .imm_word_q (imm_word_q),
      .imm_busy_q (imm_busy)
   );

   cmdf_fetch #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .base       (base_q),
      .wptr       (wptr_q),
      .run        (run_q),
      .stall_cnt  (stall_cnt),
      .imm_busy   (imm_busy),
      .imm_word   (imm_word_q),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .rptr       (rd_ptr),
      .take       (take),
      .take_word  (take_word),
      .imm_taken  (imm_taken)
   );

   cmdf_dispatch #(.NUM_SLOTS(NUM_SLOTS), .OUT_REG(OUT_REG)) u_disp (
      .clk         (clk),
      .rst_n       (rst_n),
      .take        (take),
      .word        (take_word),
      .present     (codec_present),
      .cmd_valid   (cmd_valid),
      .cmd_reject  (cmd_reject),
      .cmd_codec   (cmd_codec),
      .cmd_node    (cmd_node),
      .cmd_payload (cmd_payload)
   );

endmodule

// File: rtl/cmdf_chk.sv
module cmdf_chk #(
   parameter int unsigned PTR_W = 8,
   parameter int unsigned CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [PTR_W-1:0] rd_ptr,
   input logic [PTR_W-1:0] wptr,
   input logic             run,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] thresh,
   input logic             imm_busy,
   input logic             mem_req,
   input logic             cmd_valid,
   input logic             cmd_reject,
   input logic [3:0]       cmd_codec
);

   // R1
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ptr != $past(rd_ptr)) |-> (rd_ptr == PTR_W'($past(rd_ptr) + 1'b1)));

   // R2
   fetch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ($past(run) && ($past(rd_ptr) != $past(wptr))));

   // R3
   thresh_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ($past(cnt) != $past(thresh)));

   // R4
   imm_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !$past(imm_busy));

   // R6
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && cmd_reject));

   // R7
   no_slot15_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (cmd_codec != 4'hF));

   // R8
   single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

endmodule

bind cmd_ring_fetch cmdf_chk #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_ptr     (rd_ptr),
   .wptr       (wptr_q),
   .run        (run_q),
   .cnt        (cnt_q),
   .thresh     (thresh_q),
   .imm_busy   (imm_busy),
   .mem_req    (mem_req),
   .cmd_valid  (cmd_valid),
   .cmd_reject (cmd_reject),
   .cmd_codec  (cmd_codec)
);

// File: tb/cmd_ring_fetch_test.sv
module cmd_ring_fetch_test;
   import cmdf_pkg::*;

   localparam logic [31:0] BASE = 32'h1000_0080;
   localparam logic [14:0] PRES = 15'h7EFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic [31:0] reg_wdata = '0;
   logic        rsp_done = 1'b0;
   logic [7:0]  rd_ptr;
   logic        imm_busy, mem_req, mem_rvalid = 1'b0;
   logic [31:0] mem_addr, mem_rdata = '0;
   logic        cmd_valid, cmd_reject;
   logic [3:0]  cmd_codec;
   logic [6:0]  cmd_node;
   logic [19:0] cmd_payload;

   int n_chk = 0, n_fail = 0, n_req = 0, n_disp = 0, n_rej = 0;
   logic [7:0]  exp_rp = 8'd0, fetch_rp = 8'd0;
   logic        imm_pending = 1'b0;
   logic [31:0] imm_exp = '0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   cmd_ring_fetch uut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .rsp_done(rsp_done), .codec_present(PRES),
      .rd_ptr(rd_ptr), .imm_busy(imm_busy), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .cmd_valid(cmd_valid),
      .cmd_reject(cmd_reject), .cmd_codec(cmd_codec), .cmd_node(cmd_node),
      .cmd_payload(cmd_payload));

   function automatic logic [31:0] ring_word(input logic [7:0] i);
      return {i[3:0], ((i % 7) == 3), i[6:0] ^ 7'h2a, i, 12'h5a3};
   endfunction

   function automatic bit sendable(input logic [31:0] w);
      return !w[27] && w[31:28] != 4'hF && PRES[w[31:28]];
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // memory model: two idle cycles, then one data beat
   initial begin
      forever begin
         @(negedge clk);
         if (mem_req) begin
            logic [7:0] idx;
            fetch_rp = fetch_rp + 8'd1;
            n_req++;
            // R1: address of the pre-incremented entry
            chk(mem_addr == BASE + {22'd0, fetch_rp, 2'b00}, "R1 addr",
                mem_addr, BASE + {22'd0, fetch_rp, 2'b00});
            idx = 8'((mem_addr - BASE) >> 2);
            repeat (2) @(negedge clk);
            mem_rvalid = 1'b1; mem_rdata = ring_word(idx);
            @(negedge clk);
            mem_rvalid = 1'b0;
            // R8: index moved and command strobe raised one cycle after data
            chk(rd_ptr == fetch_rp, "R8 ptr after data", rd_ptr, fetch_rp);
            chk(cmd_valid || cmd_reject, "R8 strobe after data", 0, 1);
         end
      end
   end

   // command monitor
   initial begin
      forever begin
         @(negedge clk);
         if (cmd_valid || cmd_reject) begin
            logic [31:0] w;
            bit ok;
            if (imm_pending) begin
               w = imm_exp; imm_pending = 1'b0;
            end else begin
               exp_rp = exp_rp + 8'd1;
               w = ring_word(exp_rp);
            end
            ok = sendable(w);
            n_disp++;
            if (cmd_reject) n_rej++;
            // R6 R7: accept or refuse
            chk(cmd_valid == ok && cmd_reject == !ok, "R6/R7 verdict", {cmd_valid, cmd_reject}, {ok, !ok});
            if (ok) begin
               // R5: field split
               chk({cmd_codec, cmd_node, cmd_payload} == {w[31:28], w[26:20], w[19:0]},
                   "R5 fields", {cmd_codec, cmd_node, cmd_payload}, {w[31:28], w[26:20], w[19:0]});
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int rej0;
      settle(3);
      // R9: reset state
      chk(rd_ptr == 0 && !imm_busy && !mem_req && !cmd_valid && !cmd_reject,
          "R9 reset", {rd_ptr, imm_busy, mem_req, cmd_valid}, 0);
      rst_n = 1'b1;
      settle(2);

      wr(SEL_BASE, BASE | 32'h7F);
      wr(SEL_THRESH, 32'd200);
      wr(SEL_WPTR, 32'd5);
      settle(30);
      // R2: run clear, nothing fetched
      chk(rd_ptr == 0 && n_req == 0, "R2 run clear", rd_ptr, 0);

      wr(SEL_CTRL, 32'd1);
      settle(60);
      chk(rd_ptr == 5 && n_disp == 5, "R2 drain to write index", rd_ptr, 5);
      settle(20);
      chk(n_req == 5, "R2 ring empty holds", n_req, 5);

      // R3: threshold stall and acknowledge
      wr(SEL_THRESH, 32'd3);
      repeat (3) begin
         @(negedge clk); rsp_done = 1'b1;
         @(negedge clk); rsp_done = 1'b0;
      end
      wr(SEL_WPTR, 32'd9);
      settle(40);
      chk(rd_ptr == 5, "R3 stall at threshold", rd_ptr, 5);
      wr(SEL_ACK, 32'd0);
      settle(40);
      chk(rd_ptr == 9, "R3 resume after ack", rd_ptr, 9);

      // R3: ack and response in the same cycle, ack wins
      wr(SEL_THRESH, 32'd1);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_sel = SEL_ACK; reg_wdata = '0; rsp_done = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0; rsp_done = 1'b0;
      wr(SEL_WPTR, 32'd10);
      settle(30);
      chk(rd_ptr == 10, "R3 ack beats response", rd_ptr, 10);
      wr(SEL_THRESH, 32'd200);

      // R4: immediate and ring eligible in the same cycle
      wr(SEL_CTRL, 32'd0);
      wr(SEL_WPTR, 32'd14);
      wr(SEL_IMMW, 32'h2111_2345);
      imm_exp = 32'h2111_2345; imm_pending = 1'b1;
      wr(SEL_CTRL, 32'd3);
      settle(60);
      chk(!imm_pending && !imm_busy, "R4 immediate first and cleared", {imm_pending, imm_busy}, 0);
      chk(rd_ptr == 14, "R4 ring follows", rd_ptr, 14);

      // R4 R6: immediate with run clear, indirect bit set
      rej0 = n_rej;
      wr(SEL_IMMW, 32'h2801_2345);
      imm_exp = 32'h2801_2345; imm_pending = 1'b1;
      wr(SEL_CTRL, 32'd2);
      settle(10);
      chk(n_rej == rej0 + 1 && !imm_pending, "R6 indirect refused", n_rej, rej0 + 1);

      // R1 R7: wrap through index 255 and 0
      wr(SEL_CTRL, 32'd1);
      wr(SEL_WPTR, 32'd2);
      settle(1600);
      chk(rd_ptr == 2, "R1 wrap", rd_ptr, 2);
      chk(n_req == 258, "R8 request count", n_req, 258);
      chk(n_disp == 260, "R7 dispatch count", n_disp, 260);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule